// File: doc/BRIEF.md
# Serial Reconfiguration Sequencer for a Clock Generator

This block drives the host side of a serial reconfiguration of a clock generator. The host offers a 144-bit configuration word and a one-cycle start request. The sequencer captures the word and raises a shift enable. It then sends the word MSB first, one bit per clock. After the last bit it lowers the enable and gives a single-cycle update strobe. It then follows the generator's busy flag through its rise and its fall.

Once the flag has fallen, the sequencer can give a reset pulse to the generator, for cases where the new settings touch its dividers, multipliers, output counters or loop filter. It closes with a one-cycle completion strobe. If the busy flag fails to rise, or fails to fall, within a set window, an error strobe replaces the completion strobe.

The whole sequence can run any number of times in a row. The sequencer runs on the scan clock, which is supplied from outside and must stay at or below 100 MHz. The busy flag passes through a synchronizer of `DONE_SYNC` stages (default 2).

Top module: `cfg_scan_ctrl`

## Requirements
- R1: While reset is held and after it is released with no start, `sdata_o`, `shift_en_o`, `update_o`, `gen_reset_o`, `complete_o` and `err_o` are all low.
- R2: A start accepted at clock edge e0 raises `shift_en_o` for the cycle after e0. During that lead cycle no data bit is sampled. The first data bit is the one presented for the second rising edge at which the enable is seen high.
- R3: Exactly `CHAIN_LEN` (144) bits are sent, `cfg_word_i[CHAIN_LEN-1]` first and bit 0 last. `sdata_o` is low whenever `shift_en_o` is low.
- R4: `shift_en_o` stays high for exactly `CHAIN_LEN`+1 consecutive cycles (lead plus data), then drops.
- R5: `update_o` is high for exactly one cycle, with `shift_en_o` low. That cycle comes exactly one cycle after the first cycle with the enable low.
- R6: After the synchronized busy flag has risen and then fallen, with no reset requested, `complete_o` pulses for one cycle. The pulse comes `DONE_SYNC`+1 cycles after the cycle in which `done_i` first reads low.
- R7: If `pll_rst_req_i` was high with the accepted start, `gen_reset_o` goes high for exactly `RST_CYC` cycles. The pulse starts `DONE_SYNC`+1 cycles after `done_i` falls, and `complete_o` follows in the next cycle. If `pll_rst_req_i` was low, `gen_reset_o` never rises.
- R8: The word and the reset request are captured when the start is accepted. Starts, word changes and reset-request changes that arrive during a sequence have no effect: the same bits are sent and only one update occurs.
- R9: If the busy flag stays low for `TMO_CYC` cycles after the update, or stays high for `TMO_CYC` cycles after its synchronized rise, `err_o` pulses for one cycle instead of `complete_o`. No reset pulse is given. The pulse comes at cycle U+`TMO_CYC`+1 for a missing rise, where U is the update cycle. For a missing fall it comes at R+`DONE_SYNC`+1+`TMO_CYC`, where R is the cycle in which `done_i` rises.
- R10: Sequences can follow one another without limit, and each one behaves the same as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock, at most 100 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| cfg_word_i | input | CHAIN_LEN | Configuration word to send |
| pll_rst_req_i | input | 1 | Request a generator reset after this update |
| done_i | input | 1 | Busy/done flag from the clock generator |
| sdata_o | output | 1 | Serial configuration data |
| shift_en_o | output | 1 | Shift enable for the scan chain |
| update_o | output | 1 | Single-cycle update strobe |
| gen_reset_o | output | 1 | Reset pulse to the clock generator |
| complete_o | output | 1 | Single-cycle completion strobe |
| err_o | output | 1 | Single-cycle timeout strobe |

## Verification
A bench model of the generator samples `sdata_o` only from the second enabled edge onward, so a design that drops the lead cycle, or shifts one bit too many or too few, returns a word shifted by one position. Walking-one words at the MSB and at the LSB expose a reversed bit order. A start injected mid-shift, together with a changed word, catches a design that restarts or reloads while busy: it would send mixed bits or give two updates. Busy flags that never rise or never fall check the exact timeout cycle, and a design that counts one short or one long misses that cycle. Single-cycle busy pulses catch a design that would need the flag high for longer.

// File: rtl/cfg_scan_pkg.sv
package cfg_scan_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_GAP,
    ST_UPD,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_GRST,
    ST_FIN,
    ST_ERR
  } scan_st_e;
endpackage

// File: rtl/scan_shifter.sv
module scan_shifter #(
  parameter int LEN = 144
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [LEN-1:0] word_i,
  input  logic           shift_i,
  output logic           bit_o,
  output logic           last_o
);
  localparam int CW = $clog2(LEN);

  logic [LEN-1:0] sreg_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      sreg_q <= word_i;
      cnt_q  <= '0;
    end else if (shift_i) begin
      sreg_q <= {sreg_q[LEN-2:0], 1'b0};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = sreg_q[LEN-1];
  assign last_o = (cnt_q == CW'(LEN-1));
endmodule

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else if (STAGES == 1) ff_q <= d_i;
        else ff_q <= {ff_q[STAGES-2:0], d_i};
      end
      assign q_o = ff_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scan_watchdog.sv
module scan_watchdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (cnt_q != TW'(LIMIT - 1))  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import cfg_scan_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rst_req_i,
  input  logic last_i,
  input  logic done_s_i,
  input  logic wd_exp_i,
  output logic load_o,
  output logic shift_o,
  output logic in_shift_o,
  output logic shift_en_o,
  output logic update_o,
  output logic gen_reset_o,
  output logic complete_o,
  output logic err_o,
  output logic wd_clr_o
);
  localparam int RW = $clog2(RST_CYC + 1);

  scan_st_e      st_q, st_d;
  logic          rst_lat_q;
  logic [RW-1:0] rcnt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_i) st_d = ST_LEAD;
      ST_LEAD:    st_d = ST_SHIFT;
      ST_SHIFT:   if (last_i) st_d = ST_GAP;
      ST_GAP:     st_d = ST_UPD;
      ST_UPD:     st_d = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (done_s_i)      st_d = ST_WAIT_LO;
        else if (wd_exp_i) st_d = ST_ERR;
      end
      ST_WAIT_LO: begin
        if (!done_s_i)     st_d = rst_lat_q ? ST_GRST : ST_FIN;
        else if (wd_exp_i) st_d = ST_ERR;
      end
      ST_GRST:    if (rcnt_q == RW'(RST_CYC - 1)) st_d = ST_FIN;
      ST_FIN:     st_d = ST_IDLE;
      ST_ERR:     st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      rst_lat_q <= 1'b0;
      rcnt_q    <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) rst_lat_q <= rst_req_i;
      if (st_q == ST_GRST) rcnt_q <= rcnt_q + 1'b1;
      else                 rcnt_q <= '0;
    end
  end

  assign load_o      = (st_q == ST_IDLE) && start_i;
  assign shift_o     = (st_q == ST_SHIFT);
  assign in_shift_o  = (st_q == ST_SHIFT);
  assign shift_en_o  = (st_q == ST_LEAD) || (st_q == ST_SHIFT);
  assign update_o    = (st_q == ST_UPD);
  assign gen_reset_o = (st_q == ST_GRST);
  assign complete_o  = (st_q == ST_FIN);
  assign err_o       = (st_q == ST_ERR);
  // counter runs only while parked in one wait state
  assign wd_clr_o    = (st_d != st_q) ||
                       !((st_q == ST_WAIT_HI) || (st_q == ST_WAIT_LO));
endmodule

// File: rtl/cfg_scan_ctrl.sv
module cfg_scan_ctrl #(
  parameter int CHAIN_LEN = 144,
  parameter int TMO_CYC   = 1000,
  parameter int RST_CYC   = 4,
  parameter int DONE_SYNC = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CHAIN_LEN-1:0] cfg_word_i,
  input  logic                 pll_rst_req_i,
  input  logic                 done_i,
  output logic                 sdata_o,
  output logic                 shift_en_o,
  output logic                 update_o,
  output logic                 gen_reset_o,
  output logic                 complete_o,
  output logic                 err_o
);
  logic load, shift, in_shift, bit_out, last, done_s, wd_exp, wd_clr;

  scan_shifter #(.LEN(CHAIN_LEN)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (cfg_word_i),
    .shift_i(shift),
    .bit_o  (bit_out),
    .last_o (last)
  );

  scan_sync #(.STAGES(DONE_SYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (done_i),
    .q_o   (done_s)
  );

  scan_watchdog #(.LIMIT(TMO_CYC)) u_wd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wd_clr),
    .expired_o(wd_exp)
  );

  scan_seq_fsm #(.RST_CYC(RST_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rst_req_i  (pll_rst_req_i),
    .last_i     (last),
    .done_s_i   (done_s),
    .wd_exp_i   (wd_exp),
    .load_o     (load),
    .shift_o    (shift),
    .in_shift_o (in_shift),
    .shift_en_o (shift_en_o),
    .update_o   (update_o),
    .gen_reset_o(gen_reset_o),
    .complete_o (complete_o),
    .err_o      (err_o),
    .wd_clr_o   (wd_clr)
  );

  assign sdata_o = bit_out & in_shift;
endmodule

// File: rtl/cfg_scan_checker.sv
module cfg_scan_checker #(
  parameter int CHAIN_LEN = 144
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sdata_o,
  input logic shift_en_o,
  input logic update_o,
  input logic gen_reset_o,
  input logic complete_o,
  input logic err_o
);
  localparam int EW = $clog2(CHAIN_LEN + 2) + 1;

  logic [EW-1:0] en_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_cnt_q <= '0;
    else if (shift_en_o) en_cnt_q <= en_cnt_q + 1'b1;
    else                 en_cnt_q <= '0;
  end

  assert_en_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shift_en_o) |-> (en_cnt_q == EW'(CHAIN_LEN + 1)));

  assert_lead_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shift_en_o) |=> shift_en_o);

  assert_sdata_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_o |-> !sdata_o);

  assert_upd_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  assert_upd_no_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (!shift_en_o && !$past(shift_en_o) && $past(shift_en_o, 2)));

  assert_cmp_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o |=> !complete_o);

  assert_grst_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_reset_o |-> (!shift_en_o && !update_o && !complete_o && !err_o));

  assert_err_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!complete_o && !gen_reset_o && !shift_en_o));

  assert_err_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

bind cfg_scan_ctrl cfg_scan_checker #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sdata_o    (sdata_o),
  .shift_en_o (shift_en_o),
  .update_o   (update_o),
  .gen_reset_o(gen_reset_o),
  .complete_o (complete_o),
  .err_o      (err_o)
);

// File: tb/tb_cfg_scan_ctrl.sv
module tb_cfg_scan_ctrl;
  localparam int LEN  = 144;
  localparam int TMO  = 64;
  localparam int RSTC = 3;
  localparam int SYNC = 2;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [LEN-1:0] cfg_word_i = '0;
  logic           pll_rst_req_i = 1'b0;
  logic           done_i = 1'b0;
  logic sdata_o, shift_en_o, update_o, gen_reset_o, complete_o, err_o;

  always #5 clk_i = ~clk_i;

  cfg_scan_ctrl #(.CHAIN_LEN(LEN), .TMO_CYC(TMO), .RST_CYC(RSTC), .DONE_SYNC(SYNC)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cfg_word_i(cfg_word_i),
    .pll_rst_req_i(pll_rst_req_i), .done_i(done_i), .sdata_o(sdata_o),
    .shift_en_o(shift_en_o), .update_o(update_o), .gen_reset_o(gen_reset_o),
    .complete_o(complete_o), .err_o(err_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int tot_upd = 0;

  // monitor / generator model state
  int cyc = 0;
  int en_run, en_len, en_rise_cyc, en_fall_cyc, cap_n;
  logic [LEN-1:0] cap;
  int upd_cnt, upd_cyc, rst_cnt, rst_first, cmp_cnt, cmp_cyc, err_cnt, err_cyc;
  int dm_state, dm_cnt, dm_mode, dm_hi, dm_hold, rise_cyc, fall_cyc;

  task automatic clear_mon();
    en_run = 0; en_len = 0; en_rise_cyc = -1; en_fall_cyc = -1; cap_n = 0; cap = '0;
    upd_cnt = 0; upd_cyc = -1; rst_cnt = 0; rst_first = -1;
    cmp_cnt = 0; cmp_cyc = -1; err_cnt = 0; err_cyc = -1;
    dm_state = 0; dm_cnt = 0; rise_cyc = -1; fall_cyc = -1;
  endtask

  always @(negedge clk_i) begin
    cyc = cyc + 1;
    // scan chain model: lead edge skipped, capture from the second enabled edge
    if (shift_en_o) begin
      en_run = en_run + 1;
      if (en_run == 1) en_rise_cyc = cyc;
      if (en_run >= 2) begin cap = {cap[LEN-2:0], sdata_o}; cap_n = cap_n + 1; end
    end else if (en_run != 0) begin
      en_len = en_run; en_fall_cyc = cyc; en_run = 0;
    end
    if (gen_reset_o) begin rst_cnt = rst_cnt + 1; if (rst_first < 0) rst_first = cyc; end
    if (complete_o) begin cmp_cnt = cmp_cnt + 1; cmp_cyc = cyc; end
    if (err_o) begin err_cnt = err_cnt + 1; err_cyc = cyc; end
    // busy flag model
    if (dm_state == 1) begin
      dm_cnt = dm_cnt - 1;
      if (dm_cnt <= 0) begin done_i = 1'b1; rise_cyc = cyc; dm_state = 2; dm_cnt = dm_hold; end
    end else if (dm_state == 2 && dm_mode != 2) begin
      dm_cnt = dm_cnt - 1;
      if (dm_cnt <= 0) begin done_i = 1'b0; fall_cyc = cyc; dm_state = 0; end
    end
    if (update_o) begin
      upd_cnt = upd_cnt + 1; upd_cyc = cyc;
      if (dm_mode != 1) begin dm_state = 1; dm_cnt = dm_hi; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [LEN-1:0] rand_word();
    logic [LEN-1:0] w = '0;
    for (int i = 0; i < (LEN + 31) / 32; i++) w = {w[LEN-33:0], $urandom()};
    return w;
  endfunction

  // mode: 0 normal, 1 busy never rises, 2 busy never falls
  task automatic run_seq(input logic [LEN-1:0] word, input bit rreq, input int mode,
                         input bit inject, input int hi, input int hold);
    int s_cyc;
    int guard;
    clear_mon();
    dm_mode = mode; dm_hi = hi; dm_hold = hold;
    @(negedge clk_i); #1;
    cfg_word_i = word; pll_rst_req_i = rreq; start_i = 1'b1; s_cyc = cyc;
    @(negedge clk_i); #1;
    start_i = 1'b0; cfg_word_i = rand_word(); pll_rst_req_i = ~rreq;
    if (inject) begin
      repeat (20) @(negedge clk_i);
      #1 start_i = 1'b1; cfg_word_i = ~word;
      @(negedge clk_i); #1 start_i = 1'b0;
    end
    guard = 0;
    while (cmp_cnt == 0 && err_cnt == 0 && guard < 3000) begin
      @(posedge clk_i); #1; guard++;
    end
    repeat (10) @(posedge clk_i);
    #1;
    tot_upd += upd_cnt;
    chk(en_rise_cyc == s_cyc + 1, "R2", "enable rise cycle", en_rise_cyc, s_cyc + 1);
    chk(cap_n == LEN, "R3", "bits shifted", cap_n, LEN);
    n_tests++;
    if (cap !== word) begin
      n_fail++;
      $display("FAIL %s captured word: actual %h expected %h", inject ? "R8" : "R3", cap, word);
    end
    chk(en_len == LEN + 1, "R4", "enable length", en_len, LEN + 1);
    chk(upd_cnt == 1, inject ? "R8" : "R5", "update cycles", upd_cnt, 1);
    chk(upd_cyc == en_fall_cyc + 1, "R5", "update cycle", upd_cyc, en_fall_cyc + 1);
    if (mode == 0) begin
      chk(err_cnt == 0, "R6", "no error", err_cnt, 0);
      chk(cmp_cnt == 1, "R6", "complete count", cmp_cnt, 1);
      chk(cmp_cyc == fall_cyc + SYNC + 1 + (rreq ? RSTC : 0), rreq ? "R7" : "R6",
          "complete cycle", cmp_cyc, fall_cyc + SYNC + 1 + (rreq ? RSTC : 0));
      chk(rst_cnt == (rreq ? RSTC : 0), "R7", "reset pulse length", rst_cnt, rreq ? RSTC : 0);
      if (rreq) chk(rst_first == fall_cyc + SYNC + 1, "R7", "reset start", rst_first,
                    fall_cyc + SYNC + 1);
    end else begin
      chk(cmp_cnt == 0, "R9", "no complete on timeout", cmp_cnt, 0);
      chk(rst_cnt == 0, "R9", "no reset on timeout", rst_cnt, 0);
      chk(err_cnt == 1, "R9", "error count", err_cnt, 1);
      if (mode == 1) chk(err_cyc == upd_cyc + TMO + 1, "R9", "rise timeout cycle",
                         err_cyc, upd_cyc + TMO + 1);
      else chk(err_cyc == rise_cyc + SYNC + 1 + TMO, "R9", "fall timeout cycle",
               err_cyc, rise_cyc + SYNC + 1 + TMO);
    end
    done_i = 1'b0; dm_state = 0;
    repeat (SYNC + 2) @(posedge clk_i);
  endtask

  int n_runs = 0;

  initial begin
    void'($urandom(32'd20240611));
    clear_mon();
    dm_mode = 0; dm_hi = 1; dm_hold = 1;
    repeat (3) @(posedge clk_i);
    #1;
    chk({sdata_o, shift_en_o, update_o, gen_reset_o, complete_o, err_o} == 6'b0,
        "R1", "outputs in reset", {sdata_o, shift_en_o, update_o, gen_reset_o, complete_o, err_o}, 0);
    rst_ni = 1'b1;
    repeat (5) @(posedge clk_i);
    #1;
    chk({sdata_o, shift_en_o, update_o, gen_reset_o, complete_o, err_o} == 6'b0,
        "R1", "outputs idle", {sdata_o, shift_en_o, update_o, gen_reset_o, complete_o, err_o}, 0);

    // directed corners
    run_seq({1'b1, {(LEN-1){1'b0}}}, 1'b0, 0, 1'b0, 1, 1);  n_runs++;
    run_seq({{(LEN-1){1'b0}}, 1'b1}, 1'b1, 0, 1'b0, 3, 5);  n_runs++;
    run_seq({LEN{1'b1}}, 1'b1, 0, 1'b0, 10, 1);             n_runs++;
    run_seq({(LEN/2){2'b10}}, 1'b0, 0, 1'b1, 2, 4);         n_runs++; // R8
    run_seq(rand_word(), 1'b1, 0, 1'b1, 4, 2);              n_runs++; // R8 with reset
    run_seq(rand_word(), 1'b1, 1, 1'b0, 1, 1);              n_runs++; // R9 no rise
    run_seq(rand_word(), 1'b0, 2, 1'b0, 5, 1);              n_runs++; // R9 no fall
    // random back-to-back runs (R10)
    for (int i = 0; i < 12; i++) begin
      run_seq(rand_word(), 1'($urandom_range(0, 1)), 0, 1'b0,
              int'($urandom_range(1, 20)), int'($urandom_range(1, 20)));
      n_runs++;
    end
    chk(tot_upd == n_runs, "R10", "total updates over repeated runs", tot_upd, n_runs);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule